// File: doc/BRIEF.md
# Parallel ROM Read Sequencer

This block lets an on-chip requester fetch single bytes from an external asynchronous parallel ROM with a 17-bit byte address and an 8-bit data bus. The requester presents an address with a valid/ready handshake. The sequencer then drives the ROM address lines and one control pin, and waits a number of clock cycles worked out at elaboration from nanosecond limits. It samples the data bus and returns the byte with a one-cycle response strobe.

The control pin works either as a chip select or as an output enable, with either active level; parameters pick the function and the level. The function decides which enable-to-data limit applies. After each access the pin is released. A drive flag stays raised through a float interval so that no other bus master drives the data lines while the ROM outputs may still be on. The same recovery interval also keeps successive accesses a minimum read-cycle time apart.

Every wait is `ceil(time_ns / CLK_NS)` cycles, with a minimum of one cycle.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released: `req_ready_o`=1, `rsp_valid_o`=0, `rom_drive_o`=0, and `rom_sel_o` at its inactive level.
- R2: `req_ready_o` is 1 only while the sequencer is idle. A request presented while it is busy is not taken until the sequencer is idle again.
- R3: `rom_addr_o` takes `req_addr_i` at the clock edge that accepts a request (valid and ready both 1). It holds that value until the next acceptance.
- R4: `rom_sel_o` is active (equal to `SEL_ACT_HIGH`) only from the second cycle after acceptance up to and including the sampling cycle. It is inactive at all other times.
- R5: The data bus is sampled at the earliest edge at which two conditions hold. The address has been stable for at least ceil(T_ADDR_NS/CLK_NS) cycles. The pin has been active for at least ceil(T_EN/CLK_NS) cycles.
- R6: `rsp_valid_o` is a single-cycle pulse in the cycle after the sampling edge. `rsp_data_o` then carries the sampled byte and holds it until the next sample.
- R7: `rom_drive_o` is 1 whenever the pin is active. After the pin is released, `rom_drive_o` stays 1 for at least ceil(T_FLOAT_NS/CLK_NS) cycles.
- R8: Two acceptances are at least ceil(T_CYCLE_NS/CLK_NS) cycles apart.
- R9: `SEL_IS_OE`=0 uses T_CE_NS (150 ns) as the enable limit and `SEL_IS_OE`=1 uses T_OE_NS (70 ns). At 8 ns this gives a response 20 cycles after acceptance in chip-select mode and 19 cycles in output-enable mode.
- R10: A request held valid through a busy period is accepted in the first idle cycle. It completes with its own data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Read request valid |
| req_addr_i | input | ADDR_W | Byte address to read |
| req_ready_o | output | 1 | Sequencer idle, request accepted when valid |
| rsp_valid_o | output | 1 | One-cycle strobe for returned byte |
| rsp_data_o | output | DATA_W | Returned byte |
| rom_addr_o | output | ADDR_W | ROM address lines |
| rom_sel_o | output | 1 | ROM chip-select or output-enable pin |
| rom_data_i | input | DATA_W | ROM data bus |
| rom_drive_o | output | 1 | ROM may be driving the data bus |

## Verification
The hardest case to reach is a sample taken one cycle too early. A real bus would still show the old or floating data, but a simple bench model would already show the new byte. The bench therefore places a ROM model behind the pins. The model counts how many cycles the address has been stable and how many cycles the pin has been active, and returns a poison byte until both limits are met. A read with a premature sample then returns the wrong byte. The second hard case is a request arriving back to back. Keeping the request valid through a busy period pushes the second acceptance to the first idle cycle, which is where the cycle-time and float limits are tightest.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACCESS, ST_CAPTURE, ST_RECOVER
  } rd_state_e;

  // ns -> cycles, rounded up, at least one
  function automatic int ns2cyc(int ns, int clk_ns);
    int c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(int a, int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             zero_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (load_i)         cnt_q <= load_val_i;
    else if (cnt_q != '0)    cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);
endmodule

// File: rtl/rom_rd_pin.sv
module rom_rd_pin #(
  parameter bit ACT_HIGH = 1'b0
) (
  input  logic en_i,
  output logic sel_o
);
  generate
    if (ACT_HIGH) begin : g_high
      assign sel_o = en_i;
    end else begin : g_low
      assign sel_o = ~en_i;
    end
  endgenerate
endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int CLK_NS       = 8,
  parameter int T_ADDR_NS    = 150,
  parameter int T_CE_NS      = 150,
  parameter int T_OE_NS      = 70,
  parameter int T_CYCLE_NS   = 150,
  parameter int T_FLOAT_NS   = 70,
  parameter bit SEL_IS_OE    = 1'b0,
  parameter bit SEL_ACT_HIGH = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              req_ready_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_sel_o,
  input  logic [DATA_W-1:0] rom_data_i,
  output logic              rom_drive_o
);
  localparam int ADDR_CYC  = ns2cyc(T_ADDR_NS, CLK_NS);
  localparam int EN_CYC    = ns2cyc(SEL_IS_OE ? T_OE_NS : T_CE_NS, CLK_NS);
  localparam int RC_CYC    = ns2cyc(T_CYCLE_NS, CLK_NS);
  localparam int TURN_CYC  = ns2cyc(T_FLOAT_NS, CLK_NS);
  // address stable over SETUP+ACCESS+CAPTURE, pin active over ACCESS+CAPTURE
  localparam int ACC_CYC   = imax(imax(EN_CYC - 1, ADDR_CYC - 2), 1);
  // acceptance spacing = ACC_CYC + RECOVER + 3 (SETUP, CAPTURE, IDLE)
  localparam int REC_CYC   = imax(imax(TURN_CYC, RC_CYC - ACC_CYC - 3), 1);
  localparam int CNT_W     = $clog2(imax(ACC_CYC, REC_CYC) + 1);

  rd_state_e         state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              rvalid_q;
  logic              tmr_load, tmr_zero, pin_en;
  logic [CNT_W-1:0]  tmr_val;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:    if (req_valid_i) state_d = ST_SETUP;
      ST_SETUP:   state_d = ST_ACCESS;
      ST_ACCESS:  if (tmr_zero) state_d = ST_CAPTURE;
      ST_CAPTURE: state_d = ST_RECOVER;
      ST_RECOVER: if (tmr_zero) state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    tmr_load = (state_q == ST_SETUP) || (state_q == ST_CAPTURE);
    tmr_val  = (state_q == ST_SETUP) ? CNT_W'(ACC_CYC - 1) : CNT_W'(REC_CYC - 1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      addr_q   <= '0;
      data_q   <= '0;
      rvalid_q <= 1'b0;
    end else begin
      state_q  <= state_d;
      rvalid_q <= (state_q == ST_CAPTURE);
      if (state_q == ST_IDLE && req_valid_i) addr_q <= req_addr_i;
      if (state_q == ST_CAPTURE)             data_q <= rom_data_i;
    end
  end

  rom_rd_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (tmr_val),
    .zero_o     (tmr_zero)
  );

  assign pin_en = (state_q == ST_ACCESS) || (state_q == ST_CAPTURE);

  rom_rd_pin #(.ACT_HIGH(SEL_ACT_HIGH)) u_pin (
    .en_i  (pin_en),
    .sel_o (rom_sel_o)
  );

  assign req_ready_o = (state_q == ST_IDLE);
  assign rsp_valid_o = rvalid_q;
  assign rsp_data_o  = data_q;
  assign rom_addr_o  = addr_q;
  assign rom_drive_o = pin_en || (state_q == ST_RECOVER);
endmodule

// File: rtl/rom_rd_ctrl_chk.sv
module rom_rd_ctrl_chk #(
  parameter int ADDR_W       = 17,
  parameter bit SEL_ACT_HIGH = 1'b0,
  parameter int TURN_CYC     = 9,
  parameter int RC_CYC       = 19
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_valid_i,
  input logic              req_ready_o,
  input logic              rsp_valid_o,
  input logic [ADDR_W-1:0] rom_addr_o,
  input logic              rom_sel_o,
  input logic              rom_drive_o
);
  logic        pin_on, accept;
  logic [15:0] off_cnt, gap_cnt;

  assign pin_on = (rom_sel_o == SEL_ACT_HIGH);
  assign accept = req_valid_i && req_ready_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      off_cnt <= '0;
      gap_cnt <= '1;
    end else begin
      off_cnt <= pin_on ? '0 : ((off_cnt == '1) ? off_cnt : off_cnt + 1'b1);
      gap_cnt <= accept ? '0 : ((gap_cnt == '1) ? gap_cnt : gap_cnt + 1'b1);
    end
  end

  assert_no_accept_busy_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> !req_ready_o);

  assert_addr_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !accept |=> $stable(rom_addr_o));

  assert_idle_pin_off_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_ready_o |-> !pin_on);

  assert_rsp_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);

  assert_pin_drive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pin_on |-> rom_drive_o);

  assert_turnaround_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(rom_drive_o) |-> (int'(off_cnt) >= TURN_CYC));

  assert_cycle_time_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |-> (int'(gap_cnt) >= RC_CYC - 1));
endmodule

bind rom_rd_ctrl rom_rd_ctrl_chk #(
  .ADDR_W       (ADDR_W),
  .SEL_ACT_HIGH (SEL_ACT_HIGH),
  .TURN_CYC     (TURN_CYC),
  .RC_CYC       (RC_CYC)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .req_valid_i (req_valid_i),
  .req_ready_o (req_ready_o),
  .rsp_valid_o (rsp_valid_o),
  .rom_addr_o  (rom_addr_o),
  .rom_sel_o   (rom_sel_o),
  .rom_drive_o (rom_drive_o)
);

// File: tb/tb_rom_rd_ctrl.sv
module tb_rom_model #(
  parameter bit ACT_HIGH = 1'b0,
  parameter int NEED_A   = 19,
  parameter int NEED_E   = 19
) (
  input  logic        clk,
  input  logic [16:0] addr,
  input  logic        sel,
  output logic [7:0]  data
);
  logic [16:0] prev_addr = '0;
  int a_age = 0;
  int e_age = 0;
  logic on;
  assign on = (sel == ACT_HIGH);

  always @(negedge clk) begin
    if (addr != prev_addr) a_age = 1;
    else if (a_age < 100000) a_age = a_age + 1;
    prev_addr = addr;
    e_age = on ? e_age + 1 : 0;
  end

  always_comb begin
    if (on && a_age >= NEED_A && e_age >= NEED_E)
      data = addr[7:0] + addr[15:8] + {7'b0, addr[16]};
    else
      data = 8'hEE;
  end
endmodule

module tb_rom_rd_ctrl;
  localparam int CLK_NS = 8;
  function automatic int cyc(int ns);
    int c;
    c = (ns + CLK_NS - 1) / CLK_NS;
    return (c < 1) ? 1 : c;
  endfunction
  localparam int NA      = cyc(150);
  localparam int NE_CE   = cyc(150);
  localparam int NE_OE   = cyc(70);
  localparam int N_RC    = cyc(150);
  localparam int N_TURN  = cyc(70);

  function automatic int exp_lat(int ne);
    int a;
    a = ne - 1;
    if (NA - 2 > a) a = NA - 2;
    if (a < 1) a = 1;
    return a + 2;
  endfunction

  function automatic logic [7:0] romf(logic [16:0] x);
    return x[7:0] + x[15:8] + {7'b0, x[16]};
  endfunction

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #4 clk = ~clk;

  logic v = 1'b0, v2 = 1'b0;
  logic [16:0] a = '0, a2 = '0;
  logic rdy, rv, rs, rdrv, rdy2, rv2, rs2, rdrv2;
  logic [7:0] rd, rdat, rd2, rdat2;
  logic [16:0] ra, ra2;

  rom_rd_ctrl dut (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v), .req_addr_i(a),
    .req_ready_o(rdy), .rsp_valid_o(rv), .rsp_data_o(rd),
    .rom_addr_o(ra), .rom_sel_o(rs), .rom_data_i(rdat), .rom_drive_o(rdrv));

  tb_rom_model #(.ACT_HIGH(1'b0), .NEED_A(NA), .NEED_E(NE_CE)) u_rom (
    .clk(clk), .addr(ra), .sel(rs), .data(rdat));

  rom_rd_ctrl #(.SEL_IS_OE(1'b1), .SEL_ACT_HIGH(1'b1)) dut_oe (
    .clk_i(clk), .rst_ni(rst_ni), .req_valid_i(v2), .req_addr_i(a2),
    .req_ready_o(rdy2), .rsp_valid_o(rv2), .rsp_data_o(rd2),
    .rom_addr_o(ra2), .rom_sel_o(rs2), .rom_data_i(rdat2), .rom_drive_o(rdrv2));

  tb_rom_model #(.ACT_HIGH(1'b1), .NEED_A(NA), .NEED_E(NE_OE)) u_rom_oe (
    .clk(clk), .addr(ra2), .sel(rs2), .data(rdat2));

  int n_chk = 0, n_fail = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // timing monitors on dut
  int gap = 0, gap_viol = 0, min_gap = 1000000, n_acc = 0;
  int off = 0, turn_viol = 0, n_turn = 0;
  logic prev_drv = 1'b0;
  always @(negedge clk) begin
    if (rst_ni) begin
      if (v && rdy) begin
        if (n_acc > 0) begin
          if (gap < N_RC) gap_viol++;
          if (gap < min_gap) min_gap = gap;
        end
        n_acc++;
        gap = 1;
      end else gap++;
      off = (rs == 1'b0) ? 0 : off + 1;
      if (rs == 1'b0 && !rdrv) turn_viol++;
      if (prev_drv && !rdrv) begin
        n_turn++;
        if (off - 1 < N_TURN) turn_viol++;
      end
      prev_drv = rdrv;
    end
  end

  task automatic read_one(input logic [16:0] addr, input string tag);
    int lat;
    @(negedge clk);
    v = 1'b1; a = addr;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    v = 1'b0;
    check(ra == addr, {tag, " R3 addr driven"}, int'(ra), int'(addr));
    lat = 0;
    while (!rv && lat < 200) begin @(negedge clk); lat++; end
    check(lat == exp_lat(NE_CE), {tag, " R5 R9 latency"}, lat, exp_lat(NE_CE));
    check(rd == romf(addr), {tag, " R5 data"}, int'(rd), int'(romf(addr)));
    @(negedge clk);
    check(!rv && rd == romf(addr), {tag, " R6 single pulse, data held"}, int'(rv), 0);
  endtask

  task automatic t_reset();
    check(rdy && !rv && !rdrv && rs == 1'b1, "R1 in reset", {rdy, rv, rdrv, rs}, 4'b1001);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    check(rdy && !rv && !rdrv && rs == 1'b1, "R1 after reset", {rdy, rv, rdrv, rs}, 4'b1001);
    check(rs2 == 1'b0 && !rdrv2, "R1 R4 oe pin idle low", int'(rs2), 0);
  endtask

  task automatic t_single();
    read_one(17'h12345, "single");
    read_one(17'h0A5A5, "pattern");
  endtask

  task automatic t_bounds();
    read_one(17'h00000, "addr zero");
    read_one(17'h1FFFF, "addr top");
    read_one(17'h10001, "addr msb");
  endtask

  task automatic t_busy_b2b();
    int busy_bad = 0, lat = 0;
    logic [16:0] first = 17'h04321, second = 17'h1ABCD;
    @(negedge clk);
    v = 1'b1; a = first;
    while (!rdy) @(negedge clk);
    @(negedge clk);
    a = second;
    while (!rv) begin
      if (rdy || ra != first) busy_bad++;
      @(negedge clk);
    end
    check(busy_bad == 0, "R2 busy request ignored", busy_bad, 0);
    check(rd == romf(first), "R2 first data", int'(rd), int'(romf(first)));
    while (!rdy) @(negedge clk);
    @(negedge clk);
    v = 1'b0;
    check(ra == second, "R10 held request accepted", int'(ra), int'(second));
    while (!rv && lat < 200) begin @(negedge clk); lat++; end
    check(rd == romf(second), "R10 second data", int'(rd), int'(romf(second)));
    check(min_gap >= N_RC, "R8 min acceptance spacing", min_gap, N_RC);
  endtask

  task automatic t_oe();
    int lat = 0;
    logic [16:0] x = 17'h0BEEF;
    @(negedge clk);
    v2 = 1'b1; a2 = x;
    while (!rdy2) @(negedge clk);
    @(negedge clk);
    v2 = 1'b0;
    check(rs2 == 1'b0, "R4 oe pin off in setup", int'(rs2), 0);
    @(negedge clk);
    check(rs2 == 1'b1 && rdrv2, "R4 R7 oe pin active high", int'(rs2), 1);
    lat = 1;
    while (!rv2 && lat < 200) begin @(negedge clk); lat++; end
    check(lat == exp_lat(NE_OE), "R9 oe latency", lat, exp_lat(NE_OE));
    check(rd2 == romf(x), "R9 oe data", int'(rd2), int'(romf(x)));
  endtask

  task automatic t_timing();
    repeat (N_RC + 2) @(negedge clk);
    check(turn_viol == 0 && n_turn > 0, "R7 float interval", turn_viol, 0);
    check(gap_viol == 0, "R8 cycle time", gap_viol, 0);
    check(rdy && !rdrv && rs == 1'b1, "R2 R4 idle after runs", {rdy, rdrv, rs}, 3'b101);
  endtask

  initial begin
    t_reset();
    t_single();
    t_bounds();
    t_busy_b2b();
    t_oe();
    t_timing();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(CLK_NS * 100000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired R1 actual=0 expected=1");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule